// File: doc/BRIEF.md
# Programmable Timer and Event Counter with Pulse-Width Capture

This block is an up-counter of parameterised width that a control byte sets up. It has three ways of counting. In event mode it counts edges on an external input, and a control bit picks the edge polarity. In timer mode it counts ticks of the system clock after a power-of-two divider. In pulse-width mode it times a single pulse of the chosen polarity on the external input, counting divided ticks while the pulse lasts. When that pulse ends, the block clears its own run bit and keeps the result.

A separate reload register holds the value that is loaded back into the counter each time it wraps past all-ones. Each wrap also gives a one-cycle wake indication and, when enabled, a one-cycle interrupt request. Software programs the reload value and the control byte through a simple write port, and can read both the counter and the control byte. While a counter read strobe is held, counting pauses so that the value being read stays steady.

The external input is synchronised to the system clock with two flops, and an edge detector runs after it.

Top module: `evt_timer_top`

## Requirements
- R1: The control byte reads back as written, except bit 5, which always reads 0. Fields: bits 2:0 are the divider select, bit 3 is the edge select, bit 4 is run, and bits 7:6 are the mode.
- R2: Mode values are 01 event, 10 timer, 11 pulse width, and 00 idle. In idle mode the counter does not change, even with run set and edges on the input.
- R3: In timer mode the counter advances once every 2^sel system clocks, where sel is the divider select (000 gives every clock, 111 gives every 128 clocks).
- R4: In event mode each active edge of the input adds one count. Edge select 0 makes rising edges active and 1 makes falling edges active. Edges of the other polarity add nothing.
- R5: In pulse-width mode with run set, counting starts on the active edge and adds one per divided tick until the input returns to its idle level. With divider select 000, a pulse N clocks long adds exactly N. When the pulse ends, run clears by itself.
- R6: After a pulse-width capture, later pulses leave the count unchanged until run is written to 1 again. A new capture then counts on from the held value.
- R7: When the counter steps from all-ones, it loads the reload value instead and raises irq for one cycle while irq_en is 1.
- R8: With irq_en at 0, irq stays low on a wrap, while wake still pulses for one cycle.
- R9: In event and timer modes, run stays set across wraps and changes only through a control write.
- R10: A reload write while run is 0 also loads the counter. While run is 1, it changes only the reload register, and that value first appears in the counter at the next wrap.
- R11: While cnt_re is high, the counter holds its value. Counting resumes on the first clock after cnt_re falls.
- R12: After reset, the control byte, counter, irq and wake are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write data |
| ctrl_rdata | output | 8 | Control byte read data |
| cnt_we | input | 1 | Reload write strobe |
| cnt_wdata | input | CNT_W | Reload write data |
| cnt_re | input | 1 | Counter read strobe; pauses counting |
| cnt_rdata | output | CNT_W | Current counter value |
| irq_en | input | 1 | Interrupt request enable |
| evt_in | input | 1 | External event / pulse input (asynchronous) |
| irq | output | 1 | One-cycle interrupt request on wrap |
| wake | output | 1 | One-cycle wake indication on wrap |

## Verification
The bench builds the block with the default 8-bit counter. At this width a wrap from all-ones can be reached in a handful of ticks or edges, which makes reload, irq masking and reload-while-running easy to observe. Divider selects 3 and 7 are measured over windows that are exact multiples of their periods, so the count over the window does not depend on the divider's phase. Pulse-width capture is run with both polarities at divider select 000, so the expected result equals the pulse length in clocks.

// File: rtl/tec_pkg.sv
package tec_pkg;

    localparam int CTRL_W = 8;
    localparam int SEL_W  = 3;
    localparam int DIV_W  = (1 << SEL_W) - 1;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_TIMER = 2'b10,
        MODE_PULSE = 2'b11
    } tec_mode_e;

    typedef struct packed {
        tec_mode_e        mode;
        logic             rsvd;
        logic             run;
        logic             fall_sel;
        logic [SEL_W-1:0] sel;
    } tec_ctrl_t;

    typedef struct packed {
        logic act;
        logic ret;
    } tec_edge_t;

    function automatic tec_ctrl_t ctrl_from_byte(input logic [CTRL_W-1:0] b);
        tec_ctrl_t c;
        c      = tec_ctrl_t'(b);
        c.rsvd = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/tec_prescale.sv
module tec_prescale #(
    parameter int SW = 3,
    parameter int DW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] sel,
    output logic          tick
);
    logic [DW-1:0] div_q;
    logic [DW-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    always_comb begin
        for (int i = 0; i < DW; i++) mask[i] = (i < int'(sel));
    end

    assign tick = &(div_q | ~mask);

    // R3
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && sel != '0) |=> (!tick || sel != $past(sel)));

endmodule

// File: rtl/tec_edge_sync.sv
module tec_edge_sync
    import tec_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      din,
    input  logic      fall_sel,
    output tec_edge_t edg
);
    logic s1_q, s2_q, prev_q;
    logic rise, fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= din;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign rise    = s2_q & ~prev_q;
    assign fall    = ~s2_q & prev_q;
    assign edg.act = fall_sel ? fall : rise;
    assign edg.ret = fall_sel ? rise : fall;

    // R4
    edge_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (edg.act && $stable(fall_sel)) |=> !edg.act);

endmodule

// File: rtl/tec_core.sv
module tec_core
    import tec_pkg::*;
#(
    parameter int W = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  tec_mode_e mode,
    input  logic      run,
    input  logic      tick,
    input  tec_edge_t edg,
    input  logic      hold,
    input  logic      load_we,
    input  logic [W-1:0] load_data,
    output logic [W-1:0] cnt,
    output logic      ovf,
    output logic      pw_done
);
    logic [W-1:0] preload_q;
    logic         pw_active_q;
    logic         start, in_pulse, step;

    assign start    = (mode == MODE_PULSE) && run && !pw_active_q && edg.act;
    assign in_pulse = (pw_active_q || start) && !edg.ret;
    assign pw_done  = (mode == MODE_PULSE) && run && pw_active_q && edg.ret;

    always_comb begin
        step = 1'b0;
        if (run && !hold) begin
            unique case (mode)
                MODE_EVENT: step = edg.act;
                MODE_TIMER: step = tick;
                MODE_PULSE: step = in_pulse && tick;
                default:    step = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt         <= '0;
            preload_q   <= '0;
            ovf         <= 1'b0;
            pw_active_q <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (load_we) preload_q <= load_data;
            if (load_we && !run) begin
                cnt <= load_data;
            end else if (step) begin
                if (cnt == '1) begin
                    cnt <= preload_q;
                    ovf <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            if (!run || mode != MODE_PULSE || pw_done) pw_active_q <= 1'b0;
            else if (start)                           pw_active_q <= 1'b1;
        end
    end

    // R11
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (hold && !load_we) |=> $stable(cnt));
    // R10
    load_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (load_we && !run) |=> cnt == $past(load_data));
    // R10
    load_run_chk: assert property (@(posedge clk) disable iff (rst)
        (load_we && run) |=> (ovf || cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
    // R7
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |-> cnt == $past(preload_q));
    // R2
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_IDLE && !load_we) |=> $stable(cnt));
    // R6
    stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !load_we) |=> $stable(cnt));

endmodule

// File: rtl/evt_timer_top.sv
module evt_timer_top
    import tec_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic [7:0]       ctrl_wdata,
    output logic [7:0]       ctrl_rdata,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             cnt_re,
    output logic [CNT_W-1:0] cnt_rdata,
    input  logic             irq_en,
    input  logic             evt_in,
    output logic             irq,
    output logic             wake
);
    tec_ctrl_t ctrl_q;
    tec_edge_t edg;
    logic      tick, ovf, pw_done;

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q     <= '0;
        else if (ctrl_we) ctrl_q     <= ctrl_from_byte(ctrl_wdata);
        else if (pw_done) ctrl_q.run <= 1'b0;
    end

    tec_prescale #(.SW(SEL_W), .DW(DIV_W)) u_psc (
        .clk(clk), .rst(rst), .sel(ctrl_q.sel), .tick(tick)
    );

    tec_edge_sync u_sync (
        .clk(clk), .rst(rst), .din(evt_in), .fall_sel(ctrl_q.fall_sel), .edg(edg)
    );

    tec_core #(.W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .mode(ctrl_q.mode), .run(ctrl_q.run),
        .tick(tick), .edg(edg), .hold(cnt_re),
        .load_we(cnt_we), .load_data(cnt_wdata),
        .cnt(cnt_rdata), .ovf(ovf), .pw_done(pw_done)
    );

    assign ctrl_rdata = ctrl_q;
    assign wake       = ovf;
    assign irq        = ovf & irq_en;

    // R9
    run_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.run && !ctrl_we && ctrl_q.mode != MODE_PULSE) |=> ctrl_q.run);
    // R1
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> ctrl_rdata[5] == 1'b0);
    // R5
    pw_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (pw_done && !ctrl_we) |=> !ctrl_q.run);

endmodule

// File: tb/sim_evt_timer_top.sv
module sim_evt_timer_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic [7:0] ctrl_rdata;
    logic       cnt_we = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic       cnt_re = 1'b0;
    logic [7:0] cnt_rdata;
    logic       irq_en = 1'b0;
    logic       evt_in = 1'b0;
    logic       irq, wake;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    evt_timer_top #(.CNT_W(8)) u0 (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .cnt_re(cnt_re), .cnt_rdata(cnt_rdata), .irq_en(irq_en),
        .evt_in(evt_in), .irq(irq), .wake(wake)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic wr_cnt(input logic [7:0] v);
        @(negedge clk); cnt_we = 1'b1; cnt_wdata = v;
        @(negedge clk); cnt_we = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R12 ctrl", ctrl_rdata, 0);
        check("R12 cnt", cnt_rdata, 0);
        check("R12 irq", irq, 0);
        check("R12 wake", wake, 0);
    endtask

    task automatic t_ctrl_readback;
        wr_ctrl(8'hFF);
        check("R1 readback", ctrl_rdata, 8'hDF);
        wr_ctrl(8'h2B);
        check("R1 readback2", ctrl_rdata, 8'h0B);
        wr_ctrl(8'h00);
    endtask

    task automatic t_timer_wrap(input logic en);
        wr_ctrl(8'h00);
        wr_cnt(8'hFA);
        check("R10 stopped load", cnt_rdata, 8'hFA);
        irq_en = en;
        wr_ctrl(8'h90);
        wait_n(5);
        check("R7 pre-wrap", cnt_rdata, 8'hFF);
        check("R7 no early wake", wake, 0);
        wait_n(1);
        check("R7 reload", cnt_rdata, 8'hFA);
        check(en ? "R7 irq" : "R8 irq masked", irq, en ? 1 : 0);
        check("R8 wake", wake, 1);
        wait_n(1);
        check("R7 irq one cycle", irq, 0);
        check("R9 run kept", ctrl_rdata[4], 1);
        wr_ctrl(8'h00);
        irq_en = 1'b0;
    endtask

    task automatic t_prescale(input logic [2:0] sel, input int win, input int exp);
        logic [7:0] c0;
        wr_ctrl(8'h00);
        wr_cnt(8'h00);
        wr_ctrl({5'b10010, sel});
        c0 = cnt_rdata;
        wait_n(win);
        check("R3 divided rate", 8'(cnt_rdata - c0), exp);
        wr_ctrl(8'h00);
    endtask

    task automatic t_freeze;
        logic [7:0] c0;
        wr_ctrl(8'h00);
        wr_cnt(8'h10);
        wr_ctrl(8'h90);
        @(negedge clk); cnt_re = 1'b1;
        c0 = cnt_rdata;
        wait_n(5);
        check("R11 frozen", cnt_rdata, c0);
        cnt_re = 1'b0;
        wait_n(1);
        check("R11 resumes", cnt_rdata, 8'(c0 + 1));
        wr_ctrl(8'h00);
    endtask

    task automatic pulse(input int hi, input int gap);
        evt_in = ~evt_in;
        wait_n(hi);
        evt_in = ~evt_in;
        wait_n(gap);
    endtask

    task automatic t_event;
        evt_in = 1'b0;
        wr_ctrl(8'h00);
        wr_cnt(8'h00);
        wr_ctrl(8'h50);
        for (int i = 0; i < 3; i++) pulse(6, 6);
        check("R4 rising edges", cnt_rdata, 3);
        wr_ctrl(8'h00);
        wr_cnt(8'h00);
        wr_ctrl(8'h58);
        evt_in = 1'b1; wait_n(6);
        check("R4 rising ignored", cnt_rdata, 0);
        evt_in = 1'b0; wait_n(6);
        check("R4 falling counted", cnt_rdata, 1);
        wr_ctrl(8'h00);
    endtask

    task automatic t_preload_running;
        evt_in = 1'b0;
        wr_ctrl(8'h00);
        wr_cnt(8'hFE);
        irq_en = 1'b1;
        wr_ctrl(8'h50);
        wr_cnt(8'h33);
        wait_n(3);
        check("R10 running load kept out", cnt_rdata, 8'hFE);
        pulse(6, 6);
        check("R10 count on", cnt_rdata, 8'hFF);
        pulse(6, 6);
        check("R10 new reload at wrap", cnt_rdata, 8'h33);
        check("R9 run kept event", ctrl_rdata[4], 1);
        irq_en = 1'b0;
        wr_ctrl(8'h00);
    endtask

    task automatic t_pulse_rise;
        evt_in = 1'b0;
        wr_ctrl(8'h00);
        wait_n(4);
        wr_cnt(8'h00);
        wr_ctrl(8'hD0);
        wait_n(8);
        check("R5 waits for edge", cnt_rdata, 0);
        pulse(20, 6);
        check("R5 width", cnt_rdata, 20);
        check("R5 run cleared", ctrl_rdata[4], 0);
        pulse(5, 6);
        check("R6 held", cnt_rdata, 20);
        wr_ctrl(8'hD0);
        pulse(7, 6);
        check("R6 rearm", cnt_rdata, 27);
        wr_ctrl(8'h00);
    endtask

    task automatic t_pulse_fall;
        evt_in = 1'b1;
        wr_ctrl(8'h00);
        wait_n(6);
        wr_cnt(8'h00);
        wr_ctrl(8'hD8);
        pulse(12, 6);
        check("R5 low width", cnt_rdata, 12);
        check("R5 run cleared low", ctrl_rdata[4], 0);
        evt_in = 1'b0;
        wr_ctrl(8'h00);
        wait_n(4);
    endtask

    task automatic t_idle;
        wr_ctrl(8'h00);
        wr_cnt(8'h44);
        wr_ctrl(8'h10);
        pulse(5, 5);
        wait_n(20);
        check("R2 idle mode", cnt_rdata, 8'h44);
        wr_ctrl(8'h00);
    endtask

    initial begin
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        t_reset();
        t_ctrl_readback();
        t_timer_wrap(1'b1);
        t_timer_wrap(1'b0);
        t_prescale(3'd3, 64, 8);
        t_prescale(3'd7, 256, 2);
        t_freeze();
        t_event();
        t_preload_running();
        t_pulse_rise();
        t_pulse_fall();
        t_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule